// File: doc/BRIEF.md
# Display Raster Timing Generator

This block produces the horizontal and vertical timing for a parallel RGB display panel from one pixel clock. Eight runtime inputs give the active width, front porch, sync width and back porch of a line in pixel clocks, and the same four intervals of a frame in lines. From these the block drives a horizontal sync, a vertical sync and a data-enable. Each of the three has its own polarity and its own enable. During the active region the block also reports the pixel coordinates, and it pulses a start-of-frame strobe on the first active pixel.

Within a line the intervals run in a fixed order: active, then front porch, then sync, then back porch. Frames follow the same order in lines. The timing inputs are captured only when a frame wraps, so a frame never mixes two sets of timing. A line-doubling mode sends each active line twice before the vertical position advances. Two settings choose the clock edge that launches the outputs: one for the data group (data-enable, coordinates and strobe) and one for the sync group. By default the sync group follows the data group.

The outputs run freely and have no flow control. A pixel source beside the block has to keep pace with data-enable. Every interval length must be at least 1. Zero lengths are outside the supported range.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal position counts pixel clocks from 0 to A+F+S+B-1 and then wraps to 0, where A, F, S and B are the horizontal active, front, sync and back lengths. The raw horizontal sync is asserted for positions A+F up to A+F+S-1.
- R2: The vertical position advances once per completed line and wraps after Av+Fv+Sv+Bv lines. The raw vertical sync is asserted for lines Av+Fv up to Av+Fv+Sv-1.
- R3: Data-enable is asserted only when the horizontal position is below A and the vertical position is below Av. At those times pix_x and pix_y equal the positions. At all other times both coordinates are 0.
- R4: Each polarity input selects the asserted level of its output: 1 means asserted high and 0 means asserted low.
- R5: When the enable of hsync, vsync or data-enable is 0, that output is held at its deasserted level, which is the inverse of its polarity input.
- R6: When data_rise is 1, the data group is launched on the rising edge. When data_rise is 0, it is launched on the falling edge and shows each position half a pixel clock before the rising-edge launch would.
- R7: When sync_edge_own is 0, the sync group uses the data group's edge. When sync_edge_own is 1, sync_rise chooses its edge, with 1 for rising and 0 for falling.
- R8: With line_double set, each active line is output twice, and the vertical position holds through the first pass.
- R9: Timing inputs and line_double are captured during reset and on the clock that wraps the last pixel of a frame. Changes made at any other time take effect at the next frame.
- R10: sof_o is high for exactly one pixel clock, at position (0,0) of the first pass of a frame.
- R11: While reset is high, all three sync and enable outputs sit at their deasserted levels and sof_o, pix_x and pix_y are 0. The first output after reset is position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_act_len | input | HW | Active pixels per line |
| h_front_len | input | HW | Horizontal front porch, in pixel clocks |
| h_sync_len | input | HW | Horizontal sync width, in pixel clocks |
| h_back_len | input | HW | Horizontal back porch, in pixel clocks |
| v_act_len | input | VW | Active lines per frame |
| v_front_len | input | VW | Vertical front porch, in lines |
| v_sync_len | input | VW | Vertical sync width, in lines |
| v_back_len | input | VW | Vertical back porch, in lines |
| line_double | input | 1 | Output each active line twice |
| hs_pol | input | 1 | Asserted level of hsync_o |
| vs_pol | input | 1 | Asserted level of vsync_o |
| de_pol | input | 1 | Asserted level of de_o |
| hs_en | input | 1 | Enable for hsync_o |
| vs_en | input | 1 | Enable for vsync_o |
| de_en | input | 1 | Enable for de_o |
| data_rise | input | 1 | Data group launch edge: 1 rising, 0 falling |
| sync_edge_own | input | 1 | Sync group uses sync_rise instead of data_rise |
| sync_rise | input | 1 | Sync group launch edge when separate |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| sof_o | output | 1 | Start-of-frame strobe, active high |
| pix_x | output | HW | Horizontal pixel coordinate |
| pix_y | output | VW | Vertical line coordinate |

## Verification
A wrong counter or segment boundary shows up within one line as a sync edge or data-enable edge in the wrong place, or as a wrong coordinate. A wrong line-repeat state or a wrong configuration capture shows up at the next line end or frame wrap, as a skipped or extra line or as a frame with the wrong size. A launch register on the wrong edge shows up within half a pixel clock, because the falling-edge copy must already hold the next position when the bench samples late in the cycle. The bench therefore compares every output twice per cycle against a reference model: once just after the rising edge and once after the falling edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Output level of a strobe that has a polarity and an enable.
  function automatic logic drive_level(input logic asserted, input logic en, input logic pol);
    return (en && asserted) ? pol : ~pol;
  endfunction

  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} launch_edge_e;

endpackage

// File: rtl/dtg_axis.sv
// One raster axis: position counter plus interval decode.
module dtg_axis #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] len_act,
  input  logic [W-1:0] len_front,
  input  logic [W-1:0] len_sync,
  input  logic [W-1:0] len_back,
  output logic [W-1:0] pos,
  output logic         last,
  output logic         in_act,
  output logic         in_sync
);
  localparam int TW = W + 2;

  logic [TW-1:0] end_act, end_front, end_sync, end_total, cnt;

  always_comb begin
    end_act   = {2'b00, len_act};
    end_front = end_act + {2'b00, len_front};
    end_sync  = end_front + {2'b00, len_sync};
    end_total = end_sync + {2'b00, len_back};
  end

  assign last    = (cnt == end_total - TW'(1));
  assign in_act  = (cnt < end_act);
  assign in_sync = (cnt >= end_front) && (cnt < end_sync);
  assign pos     = cnt[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + TW'(1);
  end

  // Position never reaches the interval total (R1 horizontally, R2 vertically)
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst) cnt < end_total);

endmodule

// File: rtl/dtg_launch.sv
// Output register pair: one copy per clock edge, edge chosen by rise_sel.
module dtg_launch #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_sel,
  input  logic [W-1:0] d,
  input  logic [W-1:0] idle,
  output logic [W-1:0] q
);
  logic [W-1:0] q_rise, q_fall;
  logic         armed;

  always_ff @(posedge clk) begin
    if (rst) q_rise <= idle;
    else     q_rise <= d;
  end

  always_ff @(negedge clk) begin
    if (rst) q_fall <= idle;
    else     q_fall <= d;
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign q = rise_sel ? q_rise : q_fall;

  // Falling copy leads the rising copy by half a clock (R6)
  assert_half_lead_R6: assert property (@(posedge clk) disable iff (rst)
    armed |-> q_rise == $past(q_fall));

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_act_len,
  input  logic [HW-1:0] h_front_len,
  input  logic [HW-1:0] h_sync_len,
  input  logic [HW-1:0] h_back_len,
  input  logic [VW-1:0] v_act_len,
  input  logic [VW-1:0] v_front_len,
  input  logic [VW-1:0] v_sync_len,
  input  logic [VW-1:0] v_back_len,
  input  logic          line_double,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          de_pol,
  input  logic          hs_en,
  input  logic          vs_en,
  input  logic          de_en,
  input  logic          data_rise,
  input  logic          sync_edge_own,
  input  logic          sync_rise,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          sof_o,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y
);
  localparam int DW = 2 + HW + VW;

  // Frame-synchronous copies of the timing inputs
  logic [HW-1:0] s_ha, s_hf, s_hs, s_hb;
  logic [VW-1:0] s_va, s_vf, s_vs, s_vb;
  logic          s_dbl;

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_last, h_in_act, h_in_sync;
  logic          v_last, v_in_act, v_in_sync;
  logic          rep, v_step, frame_end;
  logic          de_raw, sof_raw;

  assign v_step    = h_last && !(s_dbl && v_in_act && !rep);
  assign frame_end = h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      s_ha  <= h_act_len;  s_hf <= h_front_len; s_hs <= h_sync_len; s_hb <= h_back_len;
      s_va  <= v_act_len;  s_vf <= v_front_len; s_vs <= v_sync_len; s_vb <= v_back_len;
      s_dbl <= line_double;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rep <= 1'b0;
    else if (h_last) rep <= s_dbl && v_in_act && !rep;
  end

  dtg_axis #(.W(HW)) u_h (
    .clk(clk), .rst(rst), .step(1'b1),
    .len_act(s_ha), .len_front(s_hf), .len_sync(s_hs), .len_back(s_hb),
    .pos(h_pos), .last(h_last), .in_act(h_in_act), .in_sync(h_in_sync)
  );

  dtg_axis #(.W(VW)) u_v (
    .clk(clk), .rst(rst), .step(v_step),
    .len_act(s_va), .len_front(s_vf), .len_sync(s_vs), .len_back(s_vb),
    .pos(v_pos), .last(v_last), .in_act(v_in_act), .in_sync(v_in_sync)
  );

  assign de_raw  = h_in_act && v_in_act;
  assign sof_raw = de_raw && (h_pos == '0) && (v_pos == '0) && !rep;

  logic [DW-1:0] data_d, data_idle, data_q;
  logic [1:0]    sync_d, sync_idle, sync_q;
  logic          sync_sel;

  assign data_d    = {drive_level(de_raw, de_en, de_pol), sof_raw,
                      de_raw ? h_pos : '0, de_raw ? v_pos : '0};
  assign data_idle = {~de_pol, 1'b0, {HW{1'b0}}, {VW{1'b0}}};
  assign sync_d    = {drive_level(h_in_sync, hs_en, hs_pol), drive_level(v_in_sync, vs_en, vs_pol)};
  assign sync_idle = {~hs_pol, ~vs_pol};
  assign sync_sel  = sync_edge_own ? sync_rise : data_rise;

  dtg_launch #(.W(DW)) u_data (
    .clk(clk), .rst(rst), .rise_sel(data_rise), .d(data_d), .idle(data_idle), .q(data_q)
  );

  dtg_launch #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .rise_sel(sync_sel), .d(sync_d), .idle(sync_idle), .q(sync_q)
  );

  assign {de_o, sof_o, pix_x, pix_y} = data_q;
  assign {hsync_o, vsync_o}          = sync_q;

  assert_sof_single_R10: assert property (@(posedge clk) disable iff (rst)
    sof_raw |=> !sof_raw);

  assert_dbl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (s_dbl && h_last && v_in_act && !rep) |=> (v_pos == $past(v_pos)) && rep);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(s_ha) && $stable(s_va) && $stable(s_hb) && $stable(s_vb) && $stable(s_dbl));

endmodule

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/100ps
module tb_disp_timing_gen;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] h_act_len, h_front_len, h_sync_len, h_back_len;
  logic [VW-1:0] v_act_len, v_front_len, v_sync_len, v_back_len;
  logic line_double, hs_pol, vs_pol, de_pol, hs_en, vs_en, de_en;
  logic data_rise, sync_edge_own, sync_rise;
  logic hsync_o, vsync_o, de_o, sof_o;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  always #2 clk = ~clk;   // 250 MHz

  disp_timing_gen #(.HW(HW), .VW(VW)) dut (.*);

  typedef struct {bit hs, vs, de, sof; int x, y;} exp_t;
  exp_t exp_q[$];

  int tests = 0, fails = 0;
  bit running = 0;
  string phase = "R1";
  // model state
  int mh = 0, mv = 0;
  bit mrep = 0;
  int sha, shf, shs, shb, sva, svf, svs, svb;
  bit sdbl;

  task automatic check(input string tag, input string what, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", tag, phase, what, act, expv, $time);
    end
  endtask

  function automatic void latch_cfg();
    sha = h_act_len; shf = h_front_len; shs = h_sync_len; shb = h_back_len;
    sva = v_act_len; svf = v_front_len; svs = v_sync_len; svb = v_back_len;
    sdbl = line_double;
  endfunction

  function automatic exp_t decode(input int h, input int v, input bit rp);
    exp_t e;
    bit de_r, hs_r, vs_r;
    de_r = (h < sha) && (v < sva);
    hs_r = (h >= sha + shf) && (h < sha + shf + shs);
    vs_r = (v >= sva + svf) && (v < sva + svf + svs);
    e.de  = (de_en && de_r) ? de_pol : !de_pol;
    e.hs  = (hs_en && hs_r) ? hs_pol : !hs_pol;
    e.vs  = (vs_en && vs_r) ? vs_pol : !vs_pol;
    e.sof = de_r && h == 0 && v == 0 && !rp;
    e.x   = de_r ? h : 0;
    e.y   = de_r ? v : 0;
    return e;
  endfunction

  function automatic void advance();
    if (mh == sha + shf + shs + shb - 1) begin
      mh = 0;
      if (sdbl && mv < sva && !mrep) mrep = 1;
      else begin
        mrep = 0;
        if (mv == sva + svf + svs + svb - 1) begin mv = 0; latch_cfg(); end
        else mv++;
      end
    end else mh++;
  endfunction

  // driver side of the scoreboard: expected item per cycle
  always @(posedge clk) if (running) begin
    #0.5;
    exp_q.push_back(decode(mh, mv, mrep));
    advance();
  end

  // monitor: early sample (both launch copies agree), late sample (after falling edge)
  always @(posedge clk) if (running) begin
    exp_t e, nx;
    #1;
    if (exp_q.size() == 0) begin
      check("R1", "queue underflow", 0, 1);
    end else begin
      e = exp_q.pop_front();
      check("R1", "hsync", hsync_o, e.hs);
      check("R2", "vsync", vsync_o, e.vs);
      check("R3", "de", de_o, e.de);
      check("R3", "pix_x", pix_x, e.x);
      check("R3", "pix_y", pix_y, e.y);
      check("R10", "sof", sof_o, e.sof);
      #2;
      nx = decode(mh, mv, mrep);
      // R6: falling launch already shows the next position
      if (data_rise) begin
        check("R6", "late de", de_o, e.de);
        check("R6", "late pix_x", pix_x, e.x);
        check("R6", "late sof", sof_o, e.sof);
      end else begin
        check("R6", "late de", de_o, nx.de);
        check("R6", "late pix_x", pix_x, nx.x);
        check("R6", "late sof", sof_o, nx.sof);
      end
      // R7: sync group edge
      if (sync_edge_own ? sync_rise : data_rise) begin
        check("R7", "late hsync", hsync_o, e.hs);
        check("R7", "late vsync", vsync_o, e.vs);
      end else begin
        check("R7", "late hsync", hsync_o, nx.hs);
        check("R7", "late vsync", vsync_o, nx.vs);
      end
    end
  end

  task automatic step_to_drive();
    @(posedge clk); #1.5;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step_to_drive();
  endtask

  bit finished = 0;

  initial begin
    h_act_len = 8; h_front_len = 2; h_sync_len = 3; h_back_len = 2;
    v_act_len = 4; v_front_len = 1; v_sync_len = 2; v_back_len = 1;
    line_double = 0; hs_pol = 1; vs_pol = 1; de_pol = 1;
    hs_en = 1; vs_en = 1; de_en = 1;
    data_rise = 1; sync_edge_own = 0; sync_rise = 1;
    run(4);
    #1;
    // R11: reset state, polarities high so idle is low
    check("R11", "reset hsync", hsync_o, 0);
    check("R11", "reset vsync", vsync_o, 0);
    check("R11", "reset de", de_o, 0);
    check("R11", "reset sof", sof_o, 0);
    check("R11", "reset pix_x", pix_x, 0);
    check("R11", "reset pix_y", pix_y, 0);
    hs_pol = 0; de_pol = 0;
    run(2);
    #1;
    check("R11", "reset hsync low pol", hsync_o, 1);
    check("R11", "reset de low pol", de_o, 1);
    hs_pol = 1; de_pol = 1;
    step_to_drive();
    latch_cfg();
    rst = 0; running = 1;
    // R1 R2 R3 R10 R11: basic raster, rising launch
    phase = "R1"; run(250);
    // R4 with falling data launch
    phase = "R4"; hs_pol = 0; vs_pol = 0; de_pol = 0; data_rise = 0; run(250);
    // R5: unused outputs idle
    phase = "R5"; hs_en = 0; de_en = 0; run(200);
    hs_en = 1; de_en = 1; vs_en = 0; hs_pol = 1; run(150);
    vs_en = 1;
    // R7: separate sync edge
    phase = "R7"; sync_edge_own = 1; sync_rise = 1; data_rise = 0; run(150);
    sync_rise = 0; data_rise = 1; run(150);
    sync_edge_own = 0;
    // R9: mid-frame change takes effect at the next frame
    phase = "R9"; run(30);
    h_act_len = 5; h_front_len = 1; h_sync_len = 1; h_back_len = 3;
    v_act_len = 3; v_front_len = 2; v_sync_len = 1; v_back_len = 2;
    run(300);
    // R8: line doubling
    phase = "R8"; line_double = 1; run(450);
    line_double = 0; run(200);
    running = 0;
    run(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule